// File: doc/BRIEF.md
# Single-Cycle BCH Error Classifier

This block is the fast decode stage for words protected by a systematic binary BCH code over GF(2^6), extended with one overall parity bit. A stored word enters on one cycle. On the next cycle the block returns the data field and a status code. If the word is intact, the data passes through unchanged. If exactly one bit has flipped, that bit is inverted. Any other damage is marked as needing the slow multi-bit corrector, and the raw data goes with that mark.

The block computes the syndromes and checks them for a single-error pattern, all in one combinational stage. It tests the overall parity and the odd syndromes S1, S3, …, S(2T-1). A word counts as a single error only when its parity is odd and every higher odd syndrome equals the matching odd power of S1. When that holds, S1 is matched against each data column of the first sub-matrix to find the failing bit. The block never solves for an error-locator polynomial. Every nonzero syndrome that fails the single-error test is diverted to the external corrector.

Word layout (W = 2^6 bits): bit positions 0 to R-1 hold the check bits, with R = 6·T. Positions R to 62 hold the data. Position 63 holds the overall parity bit, which makes the whole word even. The check bits make the sum of alpha^(i·j) over the set bits j in positions 0..62 equal zero for every odd i up to 2T-1. Alpha is a root of x^6 + x + 1.

Top module: `bch_fast_decoder`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next outputs are out_valid = 0, out_status = 0 and out_data = 0.
- R2: out_valid equals the in_valid value sampled at the previous rising edge. The result for a word presented on one edge appears after that same edge.
- R3: A valid codeword gives out_status = 0 (clean), with out_data equal to bits [62:R] of the input. A word with odd overall parity is never reported as clean.
- R4: A word with exactly one flipped bit in the data positions R..62 gives out_status = 1 (corrected), with out_data equal to the original data field.
- R5: A word with exactly one flipped bit in a check position 0..R-1 gives out_status = 1, with out_data equal to the original data field.
- R6: A word whose only flipped bit is the parity bit at position 63 gives out_status = 1, with out_data equal to the original data field.
- R7: A word with two or three flipped bits, in any positions, gives out_status = 2 (multi-bit, request slow correction). out_data then equals the received bits [62:R], left uncorrected. A word with even parity is never reported as corrected.
- R8: out_status never takes the value 3.
- R9: While in_valid is low, out_data and out_status keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The word on in_word is to be decoded |
| in_word | input | 64 | Stored word: parity bit, data field and check bits |
| out_valid | output | 1 | The result registered from the previous cycle is valid |
| out_data | output | 63-6·T (51 at T=2) | Data field, corrected when a single data error is found |
| out_status | output | 2 | 0 clean, 1 corrected, 2 multi-bit |

## Verification
The bench builds the block with T = 2 over GF(2^6). This gives a 64-bit word with 12 check bits and 51 data bits. The encoding space is small enough for the bench to build its own table from syndrome to check bits, so it can encode any data independently of the design. At this size every bit position can be hit on purpose: the lowest and highest data bits, the first and last check bits, and the parity bit. Two- and three-bit patterns, including ones that touch the parity bit, can also be placed. At distance six none of these patterns can pose as a single error, so the expected status is exact.

// File: rtl/bch_fast_pkg.sv
// Package: field constants and GF(2^m) arithmetic shared by the decoder.
// Assumes a binary field with a primitive reduction polynomial.
package bch_fast_pkg;

    localparam int GF_M = 6;
    localparam logic [GF_M:0] GF_POLY = 7'b100_0011;
    localparam int GF_N = (1 << GF_M) - 1;

    typedef logic [GF_M-1:0] gf_t;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_MULTI = 2'd2
    } fix_status_e;

    // Multiply a field element by alpha (one shift with reduction).
    function automatic gf_t gf_xtime(gf_t a);
        gf_t r;
        r = {a[GF_M-2:0], 1'b0};
        if (a[GF_M-1]) r = r ^ GF_POLY[GF_M-1:0];
        return r;
    endfunction

    // General field multiply, shift-and-add from the top bit of b.
    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t acc;
        acc = '0;
        for (int i = GF_M - 1; i >= 0; i--) begin
            acc = gf_xtime(acc);
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    // alpha^e for 0 <= e < GF_N, used only for elaboration constants.
    function automatic gf_t gf_alpha_pow(int e);
        gf_t r;
        r = gf_t'(1);
        for (int i = 0; i < GF_N; i++) begin
            if (i < e) r = gf_xtime(r);
        end
        return r;
    endfunction

endpackage

// File: rtl/bch_syndrome.sv
// Syndrome generator: overall parity and odd syndromes S(2k+1), k = 0..T-1.
// Assumes positions 0..GF_N-1 carry the BCH word and GF_N the parity bit.
module bch_syndrome
    import bch_fast_pkg::*;
#(
    parameter int T = 2
) (
    input  logic [GF_N:0]              word,
    output logic                       par,
    output logic [T-1:0][GF_M-1:0]     syn
);

    // Overall parity over every stored bit, parity bit included.
    assign par = ^word;

    for (genvar k = 0; k < T; k++) begin : g_syn
        gf_t terms [GF_N];
        gf_t acc;

        for (genvar j = 0; j < GF_N; j++) begin : g_col
            localparam gf_t COL = gf_alpha_pow(((2 * k + 1) * j) % GF_N);
            assign terms[j] = word[j] ? COL : '0;
        end

        // XOR reduction of the selected H columns for this syndrome.
        always_comb begin
            acc = '0;
            for (int i = 0; i < GF_N; i++) acc = acc ^ terms[i];
        end

        assign syn[k] = acc;
    end

endmodule

// File: rtl/bch_single_test.sv
// Single-error test and locator. A single error needs odd parity and
// S1^(2k+1) == S(2k+1) for every k >= 1. The locator marks the data
// position whose H1 column equals S1; positions below FIRST are not decoded.
module bch_single_test
    import bch_fast_pkg::*;
#(
    parameter int T     = 2,
    parameter int FIRST = 12,
    localparam int NLOC = GF_N - FIRST
) (
    input  logic                   par,
    input  logic [T-1:0][GF_M-1:0] syn,
    output logic                   is_single,
    output logic [NLOC-1:0]        loc_hot
);

    logic [T-1:0][GF_M-1:0] pw;
    logic [T-1:0]           match;
    gf_t                    sq;

    // Odd powers of S1 built by repeated multiply with S1 squared.
    assign sq       = gf_mul(syn[0], syn[0]);
    assign pw[0]    = syn[0];
    assign match[0] = 1'b1;

    for (genvar k = 1; k < T; k++) begin : g_pow
        assign pw[k]    = gf_mul(pw[k-1], sq);
        assign match[k] = (pw[k] == syn[k]);
    end

    // Single error when parity is odd and all power checks agree.
    assign is_single = par & (&match);

    for (genvar j = 0; j < NLOC; j++) begin : g_loc
        localparam gf_t COL = gf_alpha_pow(j + FIRST);
        assign loc_hot[j] = (syn[0] == COL);
    end

endmodule

// File: rtl/bch_fast_decoder.sv
// Fast-path BCH decoder top. Decodes one word per cycle in a single
// combinational stage and registers data and status together.
// Zero syndrome: clean. Single error: bit inverted (check or parity bit
// errors leave data untouched). Otherwise: multi-bit flag, raw data.
module bch_fast_decoder
    import bch_fast_pkg::*;
#(
    parameter int T = 2,
    localparam int R = GF_M * T,
    localparam int W = GF_N + 1,
    localparam int K = GF_N - R
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_word,
    output logic          out_valid,
    output logic [K-1:0]  out_data,
    output logic [1:0]    out_status
);

    logic                   par;
    logic [T-1:0][GF_M-1:0] syn;
    logic                   is_single;
    logic [K-1:0]           loc_hot;
    logic                   nonzero;
    logic [K-1:0]           data_next;
    fix_status_e            status_next;
    fix_status_e            status_q;

    bch_syndrome #(.T(T)) u_syn (
        .word (in_word),
        .par  (par),
        .syn  (syn)
    );

    bch_single_test #(.T(T), .FIRST(R)) u_single (
        .par       (par),
        .syn       (syn),
        .is_single (is_single),
        .loc_hot   (loc_hot)
    );

    // Classify the syndrome and apply the one-bit fix to the data field.
    always_comb begin
        nonzero   = par | (|syn);
        data_next = in_word[GF_N-1:R] ^ (is_single ? loc_hot : '0);
        if (!nonzero)      status_next = ST_CLEAN;
        else if (is_single) status_next = ST_FIXED;
        else               status_next = ST_MULTI;
    end

    // Output register: valid each cycle, data and status on accepted words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            status_q  <= ST_CLEAN;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= data_next;
                status_q <= status_next;
            end
        end
    end

    assign out_status = status_q;

endmodule

// File: rtl/bch_fast_decoder_chk.sv
// Checker for bch_fast_decoder: port-level temporal properties.
module bch_fast_decoder_chk
    import bch_fast_pkg::*;
#(
    parameter int T = 2,
    localparam int R = GF_M * T,
    localparam int W = GF_N + 1,
    localparam int K = GF_N - R
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [W-1:0]  in_word,
    input logic          out_valid,
    input logic [K-1:0]  out_data,
    input logic [1:0]    out_status
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                       // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                     // R2
    AST_ODD_NOT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (^in_word)) |=> (out_status != 2'd0));            // R3
    AST_EVEN_NOT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(^in_word)) |=> (out_status != 2'd1));           // R7
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_status != 2'd3));                           // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_status)));     // R9

endmodule

bind bch_fast_decoder bch_fast_decoder_chk #(.T(T)) u_chk (.*);

// File: tb/test_bch_fast_decoder.sv
// Bench for bch_fast_decoder: table of vectors, random sweep, directed cases.
module test_bch_fast_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int M_B = 6;
    localparam int T_B = 2;
    localparam int N_B = 63;
    localparam int R_B = M_B * T_B;
    localparam int W_B = N_B + 1;
    localparam int K_B = N_B - R_B;
    localparam int NV  = 12;

    localparam logic [K_B-1:0] DA = 51'h5A5A512349C3E;
    localparam logic [K_B-1:0] DB = 51'h2F00DCAFE1357;
    localparam logic [K_B-1:0] D1 = 51'h7FFFFFFFFFFFF;
    localparam logic [K_B-1:0] D0 = 51'h0;

    localparam logic [K_B-1:0] TV_DATA [NV] =
        '{DA, DB, D0, D1, DA, DB, D0, DA, DB, DA, D1, D0};
    localparam int TV_NFLIP [NV] = '{0, 0, 0, 1, 1, 1, 1, 1, 2, 2, 3, 3};
    localparam int TV_P0    [NV] = '{0, 0, 0, 12, 62, 0, 11, 63, 20, 5, 1, 12};
    localparam int TV_P1    [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 40, 63, 30, 13};
    localparam int TV_P2    [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 63, 14};
    localparam int TV_EXP   [NV] = '{0, 0, 0, 1, 1, 1, 1, 1, 2, 2, 2, 2};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [W_B-1:0]  in_word = '0;
    logic            out_valid;
    logic [K_B-1:0]  out_data;
    logic [1:0]      out_status;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [M_B-1:0] pw_tab [N_B];
    logic [R_B-1:0] enc_tbl [1 << R_B];

    always #(CLK_PERIOD / 2) clk = ~clk;

    bch_fast_decoder #(.T(T_B)) i_bch_fast_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_status (out_status)
    );

    function automatic logic [R_B-1:0] ref_syn(logic [N_B-1:0] v);
        logic [R_B-1:0] s;
        s = '0;
        for (int k = 0; k < T_B; k++) begin
            for (int j = 0; j < N_B; j++) begin
                if (v[j]) s[k*M_B +: M_B] = s[k*M_B +: M_B] ^ pw_tab[((2*k+1)*j) % N_B];
            end
        end
        return s;
    endfunction

    function automatic logic [W_B-1:0] encode(logic [K_B-1:0] d);
        logic [N_B-1:0] v;
        v = {d, {R_B{1'b0}}};
        v[R_B-1:0] = enc_tbl[ref_syn(v)];
        return {^v, v};
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(logic [W_B-1:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic string req_of(int nflip, int pos);
        if (nflip == 0) return "R3";
        if (nflip >= 2) return "R7";
        if (pos == N_B) return "R6";
        if (pos < R_B)  return "R5";
        return "R4";
    endfunction

    task automatic run_case(logic [K_B-1:0] d, int nflip, int p0, int p1, int p2, int exp_st);
        logic [W_B-1:0] w;
        logic [K_B-1:0] exp_d;
        string req;
        w = encode(d);
        if (nflip >= 1) w[p0] = ~w[p0];
        if (nflip >= 2) w[p1] = ~w[p1];
        if (nflip >= 3) w[p2] = ~w[p2];
        exp_d = (exp_st == 2) ? w[N_B-1:R_B] : d;
        req = req_of(nflip, p0);
        send(w);
        check("R2", "valid", 64'(out_valid), 64'd1);
        check(req, "status", 64'(out_status), 64'(exp_st));
        check(req, "data", 64'(out_data), 64'(exp_d));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [W_B-1:0] w_keep;
        for (int i = 0; i < N_B; i++) begin
            logic [M_B-1:0] r;
            r = 6'd1;
            for (int e = 0; e < i; e++) r = {r[4:0], 1'b0} ^ (r[5] ? 6'b000011 : 6'b0);
            pw_tab[i] = r;
        end
        for (int p = 0; p < (1 << R_B); p++) begin
            enc_tbl[ref_syn({{K_B{1'b0}}, R_B'(p)})] = R_B'(p);
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "valid", 64'(out_valid), 64'd0);
        check("R1", "status", 64'(out_status), 64'd0);
        check("R1", "data", 64'(out_data), 64'd0);
        rst_n = 1'b1;

        // Vector table: R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            run_case(TV_DATA[v], TV_NFLIP[v], TV_P0[v], TV_P1[v], TV_P2[v], TV_EXP[v]);
        end

        // Random sweep over flip counts 0, 1, 2
        for (int n = 0; n < 60; n++) begin
            logic [K_B-1:0] d;
            int p0, p1, nf;
            d  = {$urandom, $urandom}[K_B-1:0];
            nf = n % 3;
            p0 = int'($urandom_range(0, W_B - 1));
            p1 = (p0 + 1 + int'($urandom_range(0, W_B - 2))) % W_B;
            run_case(d, nf, p0, p1, 0, (nf == 0) ? 0 : nf);
        end

        // R9: idle cycles hold the last result; R2: valid drops
        run_case(DB, 1, 33, 0, 0, 1);
        w_keep = encode(DA);
        @(negedge clk);
        in_word = w_keep;
        @(negedge clk);
        check("R2", "valid idle", 64'(out_valid), 64'd0);
        check("R9", "data hold", 64'(out_data), 64'(DB));
        check("R9", "status hold", 64'(out_status), 64'd1);

        // R2: back-to-back words, one result per cycle
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = encode(DA) ^ (64'd1 << 40);
        @(negedge clk);
        in_word  = encode(D1);
        check("R4", "b2b first status", 64'(out_status), 64'd1);
        check("R4", "b2b first data", 64'(out_data), 64'(DA));
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "b2b second valid", 64'(out_valid), 64'd1);
        check("R3", "b2b second data", 64'(out_data), 64'(D1));

        // R1: reset in mid-run clears the outputs
        run_case(DA, 2, 3, 50, 0, 2);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "mid reset valid", 64'(out_valid), 64'd0);
        check("R1", "mid reset status", 64'(out_status), 64'd0);
        check("R1", "mid reset data", 64'(out_data), 64'd0);
        rst_n = 1'b1;

        // R8: status legal after a full sweep of single positions
        for (int p = 0; p < W_B; p++) begin
            run_case(DB, 1, p, 0, 0, 1);
            check("R8", "status legal", 64'(out_status != 2'd3), 64'd1);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule